// File: doc/BRIEF.md
# Staircase Soft-Start Reference Sequencer

This block produces the digital code that sets the error-amplifier reference of a step-down regulator during start-up. Once every run condition holds, the code climbs from zero to full scale in equal increments. Each increment lasts a fixed number of switching-cycle ticks, so the ramp time scales with the switching frequency rather than with wall-clock time. A digital-to-analog stage outside this block turns the code into the reference voltage.

There are three run conditions: inhibit low, the undervoltage monitor reporting good, and no thermal fault. Losing any of them drops the code to zero and parks the sequencer in its idle state. A thermal fault is latched and only releases on a separate clear input, which models the hysteresis of the temperature sensor. The current limiter can raise a hiccup request once the output is in regulation. The sequencer then forces the code to zero for exactly one full ramp duration, counted in ticks, and afterwards starts a fresh ramp.

Top module: `ssref_seq`

## Requirements
- R1: While reset is asserted, `ref_code` is 0 and both `ss_active` and `ss_done` are low.
- R2: In the idle state with all run conditions true, the next clock edge starts a ramp: `ss_active` rises and `ref_code` is 0. A tick on that edge is not counted.
- R3: During a ramp the code changes only on clock edges where `sw_tick` is high. Edges without a tick leave `ref_code` and the flags unchanged.
- R4: After n counted ticks of a ramp, `ref_code` equals floor(n/32), and it rises by exactly one per step. On the 2016th tick it reaches 63. On that same edge `ss_active` falls and `ss_done` rises.
- R5: Once done, the code stays at 63 and `ss_done` stays high while the run conditions hold and no hiccup request arrives, whatever the ticks do.
- R6: A `hiccup_req` seen while done forces `ref_code` to 0 and both flags low on the next edge. The code is held at 0 for 2048 ticks. On the 2048th tick a new ramp starts (`ss_active` high, code 0), and the code reaches 1 after 32 further ticks.
- R7: A `hiccup_req` during a ramp or during the zero hold has no effect on the code, the flags or the timing.
- R8: With `inhibit` high, the next edge sets the code to 0 and both flags low, and they stay there regardless of ticks. Releasing `inhibit` starts a fresh ramp from 0 as in R2.
- R9: With `uv_good` low, the sequencer behaves as in R8. When `uv_good` returns high, a fresh ramp starts.
- R10: A high `therm_fault` forces the idle zero state on the next edge and is latched. The latch stays set after the fault input falls. A `therm_clear` pulse releases it only when `therm_fault` is low. The ramp restarts on the edge after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| inhibit | input | 1 | High disables the regulator |
| uv_good | input | 1 | High when the input supply is above its undervoltage threshold |
| therm_fault | input | 1 | High while the over-temperature detector trips |
| therm_clear | input | 1 | Pulse that releases a latched thermal fault once the temperature has fallen |
| hiccup_req | input | 1 | Current-limiter request for a hiccup restart |
| ref_code | output | 6 | Reference code for the external DAC |
| ss_active | output | 1 | High while the ramp is in progress |
| ss_done | output | 1 | High once the code has reached full scale |

## Verification
The properties assume that `sw_tick` is a synchronous single-clock pulse. They also assume that every control input changes only between clock edges, so that each edge sees one settled combination of run conditions. The bench drives all inputs one time unit after the rising edge and samples outputs at the same point. It walks every tick of a full ramp and every tick of the hiccup hold, and inserts idle edges without ticks to show the code holds. Hiccup pulses are placed inside the ramp and inside the hold to show they are ignored there.

// File: rtl/ssref_pkg.sv
package ssref_pkg;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_DONE = 2'd2,
        SS_HOLD = 2'd3
    } ss_state_e;

endpackage

// File: rtl/ssref_therm_latch.sv
module ssref_therm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic clear_in,
    output logic latched_q
);

    logic latch_d, latch_q;

    always_comb begin
        latch_d = latch_q;
        if (fault_in) begin
            latch_d = 1'b1;
        end else if (clear_in) begin
            latch_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else begin
            latch_q <= latch_d;
        end
    end

    assign latched_q = latch_q;

    // R10: a fault sample is always remembered
    a_r10_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> latched_q);

    // R10: clear is ignored while the fault input is still high
    a_r10_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_in && clear_in) |=> latched_q);

endmodule

// File: rtl/ssref_cycle_counter.sv
module ssref_cycle_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count_q
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_q = cnt_q;

    // R3: the tick count only advances by one or returns to zero
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> (count_q == $past(count_q) || count_q == $past(count_q) + W'(1)));

    // R3: without an increment request the count cannot grow
    a_r3_count_needs_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count_q));

endmodule

// File: rtl/ssref_seq.sv
module ssref_seq
    import ssref_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int STEP_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_tick,
    input  logic              inhibit,
    input  logic              uv_good,
    input  logic              therm_fault,
    input  logic              therm_clear,
    input  logic              hiccup_req,
    output logic [CODE_W-1:0] ref_code,
    output logic              ss_active,
    output logic              ss_done
);

    localparam int              CNT_W    = CODE_W + STEP_LOG2;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        ss_state_e         state;
        logic [CODE_W-1:0] code;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             therm_hold;
    logic             run_ok;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt_q;
    logic             step_end, hold_end;

    ssref_therm_latch u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_in  (therm_fault),
        .clear_in  (therm_clear),
        .latched_q (therm_hold)
    );

    ssref_cycle_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .count_q (cnt_q)
    );

    assign run_ok   = !inhibit && uv_good && !therm_fault && !therm_hold;
    assign step_end = &cnt_q[STEP_LOG2-1:0];
    assign hold_end = &cnt_q;

    always_comb begin
        ctl_d   = ctl_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!run_ok) begin
            ctl_d.state = SS_IDLE;
            ctl_d.code  = '0;
            cnt_clr     = 1'b1;
        end else begin
            case (ctl_q.state)
                SS_IDLE: begin
                    ctl_d.state = SS_RAMP;
                    ctl_d.code  = '0;
                    cnt_clr     = 1'b1;
                end
                SS_RAMP: begin
                    if (sw_tick) begin
                        cnt_inc = 1'b1;
                        if (step_end) begin
                            ctl_d.code = ctl_q.code + CODE_W'(1);
                            if (ctl_q.code + CODE_W'(1) == CODE_MAX) begin
                                ctl_d.state = SS_DONE;
                                cnt_clr     = 1'b1;
                            end
                        end
                    end
                end
                SS_DONE: begin
                    cnt_clr = 1'b1;
                    if (hiccup_req) begin
                        ctl_d.state = SS_HOLD;
                        ctl_d.code  = '0;
                    end
                end
                SS_HOLD: begin
                    ctl_d.code = '0;
                    if (sw_tick) begin
                        if (hold_end) begin
                            ctl_d.state = SS_RAMP;
                            cnt_clr     = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: begin
                    ctl_d.state = SS_IDLE;
                    ctl_d.code  = '0;
                    cnt_clr     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: SS_IDLE, code: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ref_code  = ctl_q.code;
    assign ss_active = (ctl_q.state == SS_RAMP);
    assign ss_done   = (ctl_q.state == SS_DONE);

    // R3: a nonzero code change needs a tick on that edge
    a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code != '0 && !$stable(ref_code)) |-> $past(sw_tick));

    // R4: the code climbs by at most one per edge
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code != '0) |-> (ref_code == $past(ref_code) || ref_code == $past(ref_code) + CODE_W'(1)));

    // R4: the two flags are never high together
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_active && ss_done));

    // R4: done implies full scale
    a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ref_code == CODE_MAX));

    // R5: regulation persists without a disturbance
    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && run_ok && !hiccup_req) |=> (ss_done && ref_code == CODE_MAX));

    // R6: hiccup in regulation zeroes the reference at once
    a_r6_hiccup_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && run_ok && hiccup_req) |=> (ref_code == '0 && !ss_done && !ss_active));

    // R8: inhibit forces the idle zero state
    a_r8_inhibit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (ref_code == '0 && !ss_active && !ss_done));

    // R9: undervoltage forces the idle zero state
    a_r9_uv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_good |=> (ref_code == '0 && !ss_active && !ss_done));

    // R10: a thermal fault forces the idle zero state
    a_r10_therm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        therm_fault |=> (ref_code == '0 && !ss_active && !ss_done));

endmodule

// File: tb/ssref_seq_tb_top.sv
module ssref_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_tick, inhibit, uv_good, therm_fault, therm_clear, hiccup_req;
    logic [5:0] ref_code;
    logic       ss_active, ss_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssref_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_tick     (sw_tick),
        .inhibit     (inhibit),
        .uv_good     (uv_good),
        .therm_fault (therm_fault),
        .therm_clear (therm_clear),
        .hiccup_req  (hiccup_req),
        .ref_code    (ref_code),
        .ss_active   (ss_active),
        .ss_done     (ss_done)
    );

    function automatic int pk(input int act, input int dn, input int code);
        return (act << 7) | (dn << 6) | code;
    endfunction

    function automatic int obs();
        return pk(int'(ss_active), int'(ss_done), int'(ref_code));
    endfunction

    function automatic int ramp_exp(input int n);
        int c;
        c = n / 32;
        if (c >= 63) return pk(0, 1, 63);
        return pk(1, 0, c);
    endfunction

    task automatic chk(input string tag, input int exp);
        int act;
        act = obs();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual act/done/code=%0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, act >> 7, (act >> 6) & 1, act & 63, exp >> 7, (exp >> 6) & 1, exp & 63);
        end
    endtask

    task automatic cyc(input logic t);
        sw_tick = t;
        @(posedge clk);
        #1;
        sw_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sw_tick = 1'b0; inhibit = 1'b0; uv_good = 1'b1;
        therm_fault = 1'b0; therm_clear = 1'b0; hiccup_req = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", pk(0, 0, 0));
        rst_n = 1'b1;

        cyc(1'b1);
        chk("R2 ramp start", pk(1, 0, 0));

        // full ramp, with untimed edges sprinkled in
        for (int i = 1; i <= 2016; i++) begin
            if (i % 3 == 0) begin
                cyc(1'b0);
                chk("R3 no tick no change", ramp_exp(i - 1));
            end
            cyc(1'b1);
            chk("R4 ramp code", ramp_exp(i));
        end

        for (int i = 0; i < 100; i++) begin
            cyc(i[0]);
            chk("R5 done holds", pk(0, 1, 63));
        end

        hiccup_req = 1'b1;
        cyc(1'b0);
        hiccup_req = 1'b0;
        chk("R6 hiccup zero", pk(0, 0, 0));

        for (int i = 1; i <= 2047; i++) begin
            if (i == 1000) begin
                hiccup_req = 1'b1;
                cyc(1'b1);
                hiccup_req = 1'b0;
                chk("R7 hiccup in hold", pk(0, 0, 0));
            end else begin
                cyc(1'b1);
                chk("R6 hold zero", pk(0, 0, 0));
            end
        end
        cyc(1'b1);
        chk("R6 ramp after hold", pk(1, 0, 0));

        for (int i = 1; i <= 40; i++) begin
            if (i == 10) begin
                hiccup_req = 1'b1;
                cyc(1'b1);
                hiccup_req = 1'b0;
                chk("R7 hiccup in ramp", ramp_exp(i));
            end else begin
                cyc(1'b1);
                chk("R6 second ramp", ramp_exp(i));
            end
        end

        inhibit = 1'b1;
        cyc(1'b0);
        chk("R8 inhibit zero", pk(0, 0, 0));
        for (int i = 0; i < 40; i++) begin
            cyc(1'b1);
            chk("R8 inhibit holds", pk(0, 0, 0));
        end
        inhibit = 1'b0;
        cyc(1'b1);
        chk("R8 restart", pk(1, 0, 0));
        for (int i = 1; i <= 32; i++) cyc(1'b1);
        chk("R8 restart code", pk(1, 0, 1));

        uv_good = 1'b0;
        cyc(1'b1);
        chk("R9 uv zero", pk(0, 0, 0));
        cyc(1'b1);
        chk("R9 uv holds", pk(0, 0, 0));
        uv_good = 1'b1;
        cyc(1'b0);
        chk("R9 restart", pk(1, 0, 0));

        therm_fault = 1'b1;
        cyc(1'b0);
        chk("R10 fault zero", pk(0, 0, 0));
        therm_fault = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1);
            chk("R10 latched", pk(0, 0, 0));
        end
        therm_fault = 1'b1;
        therm_clear = 1'b1;
        cyc(1'b0);
        therm_fault = 1'b0;
        therm_clear = 1'b0;
        cyc(1'b0);
        chk("R10 clear blocked", pk(0, 0, 0));
        therm_clear = 1'b1;
        cyc(1'b0);
        therm_clear = 1'b0;
        chk("R10 clearing edge", pk(0, 0, 0));
        cyc(1'b0);
        chk("R10 restart", pk(1, 0, 0));

        finish_run();
    end

endmodule